// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

The selector takes two IEEE-754 operands and returns one of them, unchanged, according to a two-bit operation: signed minimum, signed maximum, smaller magnitude, or larger magnitude. It does no arithmetic beyond comparing bit patterns and raises no exception flags. A precision input chooses between double (full 64-bit word) and single (low 32 bits of each operand word, upper bits ignored) interpretation. NaN operands follow a fixed preference: a lone NaN loses to the other operand, and when both are NaN the first operand wins.

Operands enter through a valid/ready input port and the chosen value leaves through a valid/ready output port held in a single register stage. An operand pair is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output word and flag stay frozen and no new pair is taken. A drain and a fresh capture can happen on the same edge, so a full rate of one result per cycle is possible.

Top module: `fpsel_top`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: When both operands are NaN (exponent all ones, fraction nonzero in the selected precision), the result is operand `a`.
- R3: When exactly one operand is NaN, the result is the other operand.
- R4: Operation code 2'b00 (minimum) returns `b` when `a` is greater than or equal to `b`, otherwise `a`; the result is always bit-identical to one operand.
- R5: Operation code 2'b01 (maximum) returns `b` when `a` is less than or equal to `b`, otherwise `a`.
- R6: Operation code 2'b10 (minimum magnitude) returns the operand whose absolute value is smaller.
- R7: Operation code 2'b11 (maximum magnitude) returns the operand whose absolute value is larger.
- R8: For both magnitude operations, equal absolute values resolve to the operand with the larger signed value; ordering uses sign-magnitude bit patterns, so +0 is greater than -0 and infinities order as the extremes.
- R9: With `dbl` = 0 only bits [31:0] of each operand are interpreted, bits [63:32] of the operands have no effect, and `out_data[63:32]` is zero; with `dbl` = 1 the whole word is used.
- R10: A pair accepted on a clock edge produces its result with `out_valid` = 1 immediately after that edge; with `out_ready` high and no input, `out_valid` falls after the next edge.
- R11: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_data` and `out_valid` hold their values across the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Selector can take a pair this cycle |
| op | input | 2 | 00 min, 01 max, 10 min magnitude, 11 max magnitude |
| dbl | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits [31:0] |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Selected operand (upper half zero in single mode) |

## Verification
The two functions that share a cycle are draining a held result and capturing the next operand pair: with `out_ready` low the bench first fills the register, offers a different pair and confirms `in_ready` stays low and the old value stays put. It then raises `out_ready` while the new pair is still offered, so one edge both empties and refills the register, and judges that the following cycle shows the new pair's selection with `out_valid` still high. The bulk of checking sweeps every pairing of twelve special values (zeros of both signs, ones, twos, infinities, NaNs, a subnormal and the most negative finite) across all four operations in both precisions, with single-mode upper halves filled with junk.

// File: rtl/fpsel_pkg.sv
package fpsel_pkg;

  typedef enum logic [1:0] {
    OP_MIN    = 2'b00,
    OP_MAX    = 2'b01,
    OP_MINMAG = 2'b10,
    OP_MAXMAG = 2'b11
  } fpsel_op_e;

endpackage

// File: rtl/fpsel_field.sv
// Splits one IEEE-754 word into sign, magnitude and a NaN indicator.
module fpsel_field #(
  parameter int W   = 64,
  parameter int EXP = 11
) (
  input  logic [W-1:0] word,
  output logic         sign,
  output logic [W-2:0] mag,
  output logic         is_nan
);
  localparam int FRAC = W - 1 - EXP;

  logic [EXP-1:0]  exp_bits;
  logic [FRAC-1:0] frac_bits;

  always_comb begin
    sign      = word[W-1];
    mag       = word[W-2:0];
    exp_bits  = word[W-2 -: EXP];
    frac_bits = word[FRAC-1:0];
    is_nan    = (&exp_bits) && (|frac_bits);
  end
endmodule

// File: rtl/fpsel_order.sv
// Sign-magnitude ordering of two normalised operands.
module fpsel_order #(
  parameter int MW = 63
) (
  input  logic          sa,
  input  logic [MW-1:0] ma,
  input  logic          sb,
  input  logic [MW-1:0] mb,
  output logic          a_gt_b,
  output logic          a_eq_b,
  output logic          mag_gt,
  output logic          mag_eq
);
  always_comb begin
    mag_gt = ma > mb;
    mag_eq = ma == mb;
    a_eq_b = (sa == sb) && mag_eq;
    if (sa != sb)
      a_gt_b = !sa;          // the positive one wins, including +0 over -0
    else if (!sa)
      a_gt_b = mag_gt;
    else
      a_gt_b = !mag_gt && !mag_eq;
  end
endmodule

// File: rtl/fpsel_pick.sv
// Decides which operand is forwarded.
module fpsel_pick
  import fpsel_pkg::*;
(
  input  logic [1:0] op,
  input  logic       nan_a,
  input  logic       nan_b,
  input  logic       a_gt_b,
  input  logic       a_eq_b,
  input  logic       mag_gt,
  input  logic       mag_eq,
  output logic       take_b
);
  logic mag_lt;
  logic tie_pick;

  always_comb begin
    mag_lt   = !mag_gt && !mag_eq;
    tie_pick = !a_gt_b;      // equal magnitudes: keep the larger signed value
    if (nan_a && nan_b)
      take_b = 1'b0;
    else if (nan_a)
      take_b = 1'b1;
    else if (nan_b)
      take_b = 1'b0;
    else begin
      unique case (fpsel_op_e'(op))
        OP_MIN:    take_b = a_gt_b || a_eq_b;
        OP_MAX:    take_b = !a_gt_b;
        OP_MINMAG: take_b = mag_gt ? 1'b1 : (mag_lt ? 1'b0 : tie_pick);
        OP_MAXMAG: take_b = mag_lt ? 1'b1 : (mag_gt ? 1'b0 : tie_pick);
        default:   take_b = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/fpsel_top.sv
module fpsel_top #(
  parameter int DW   = 64,
  parameter int SW   = 32,
  parameter int DEXP = 11,
  parameter int SEXP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    op,
  input  logic          dbl,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int MW  = DW - 1;
  localparam int SMW = SW - 1;

  logic [1:0][DW-1:0] opnd;
  logic [1:0]         n_sign;
  logic [1:0][MW-1:0] n_mag;
  logic [1:0]         n_nan;

  assign opnd[0] = a;
  assign opnd[1] = b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    logic           d_sign, s_sign, d_nan, s_nan;
    logic [MW-1:0]  d_mag;
    logic [SMW-1:0] s_mag;

    fpsel_field #(.W(DW), .EXP(DEXP)) u_dfield (
      .word(opnd[i]), .sign(d_sign), .mag(d_mag), .is_nan(d_nan)
    );
    fpsel_field #(.W(SW), .EXP(SEXP)) u_sfield (
      .word(opnd[i][SW-1:0]), .sign(s_sign), .mag(s_mag), .is_nan(s_nan)
    );

    always_comb begin
      if (dbl) begin
        n_sign[i] = d_sign;
        n_mag[i]  = d_mag;
        n_nan[i]  = d_nan;
      end else begin
        n_sign[i] = s_sign;
        n_mag[i]  = {{(MW-SMW){1'b0}}, s_mag};
        n_nan[i]  = s_nan;
      end
    end
  end

  logic a_gt_b, a_eq_b, mag_gt, mag_eq, take_b;

  fpsel_order #(.MW(MW)) u_order (
    .sa(n_sign[0]), .ma(n_mag[0]), .sb(n_sign[1]), .mb(n_mag[1]),
    .a_gt_b(a_gt_b), .a_eq_b(a_eq_b), .mag_gt(mag_gt), .mag_eq(mag_eq)
  );

  fpsel_pick u_pick (
    .op(op), .nan_a(n_nan[0]), .nan_b(n_nan[1]),
    .a_gt_b(a_gt_b), .a_eq_b(a_eq_b), .mag_gt(mag_gt), .mag_eq(mag_eq),
    .take_b(take_b)
  );

  logic [DW-1:0] chosen;
  logic [DW-1:0] result;

  always_comb begin
    chosen = take_b ? b : a;
    result = dbl ? chosen : {{(DW-SW){1'b0}}, chosen[SW-1:0]};
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= result;
    end
  end
endmodule

// File: rtl/fpsel_checker.sv
module fpsel_checker #(
  parameter int DW = 64,
  parameter int SW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    op,
  input logic          dbl,
  input logic [DW-1:0] a,
  input logic [DW-1:0] b,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  logic a_nan_d, b_nan_d, take;
  assign a_nan_d = (&a[DW-2:52]) && (|a[51:0]);
  assign b_nan_d = (&b[DW-2:52]) && (|b[51:0]);
  assign take    = in_valid && in_ready;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_both_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && dbl && a_nan_d && b_nan_d |=> out_data == $past(a));

  // R4: every result is one of the two operands
  p_is_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && dbl |=> (out_data == $past(a)) || (out_data == $past(b)));

  p_single_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && !dbl |=> out_data[DW-1:SW] == '0);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  logic unused_ok;
  assign unused_ok = ^op;
endmodule

bind fpsel_top fpsel_checker #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op(op), .dbl(dbl), .a(a), .b(b), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/fpsel_top_bench.sv
`timescale 1ns/1ps
module fpsel_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'b00;
  logic        dbl = 1'b1;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  fpsel_top u_fpsel_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .dbl(dbl), .a(a), .b(b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not end, got %0d cycles expected < 20000", cycles);
      finish_run();
    end
  end

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] special(int i, logic d);
    if (d) begin
      case (i)
        0: return 64'h0000_0000_0000_0000;
        1: return 64'h8000_0000_0000_0000;
        2: return 64'h3FF0_0000_0000_0000;
        3: return 64'hBFF0_0000_0000_0000;
        4: return 64'h4000_0000_0000_0000;
        5: return 64'hC000_0000_0000_0000;
        6: return 64'h7FF0_0000_0000_0000;
        7: return 64'hFFF0_0000_0000_0000;
        8: return 64'h7FF8_0000_0000_0000;
        9: return 64'hFFF0_0000_0000_0001;
        10: return 64'h0000_0000_0000_0001;
        default: return 64'hFFEF_FFFF_FFFF_FFFF;
      endcase
    end else begin
      case (i)
        0: return 64'h0000_0000;
        1: return 64'h8000_0000;
        2: return 64'h3F80_0000;
        3: return 64'hBF80_0000;
        4: return 64'h4000_0000;
        5: return 64'hC000_0000;
        6: return 64'h7F80_0000;
        7: return 64'hFF80_0000;
        8: return 64'h7FC0_0000;
        9: return 64'hFF80_0001;
        10: return 64'h0000_0001;
        default: return 64'hFF7F_FFFF;
      endcase
    end
  endfunction

  // Value in the selected precision, as an unsigned word.
  function automatic logic [63:0] narrow(logic [63:0] v, logic d);
    return d ? v : {32'h0, v[31:0]};
  endfunction

  function automatic logic is_nan(logic [63:0] v, logic d);
    if (d) return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  // Monotone key: larger signed value gives larger unsigned key.
  function automatic logic [63:0] order_key(logic [63:0] v, logic d);
    logic [63:0] w = narrow(v, d);
    logic [63:0] top = d ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    if (w & top) return (top - 64'd1) - (w & ~top);  // negative: bigger mag lower
    return w + top;
  endfunction

  function automatic logic [63:0] magnitude(logic [63:0] v, logic d);
    return d ? {1'b0, v[62:0]} : {33'h0, v[30:0]};
  endfunction

  function automatic logic [63:0] expect_sel(logic [63:0] x, logic [63:0] y,
                                             logic [1:0] o, logic d);
    logic [63:0] ka = order_key(x, d), kb = order_key(y, d);
    logic [63:0] ma = magnitude(x, d), mb = magnitude(y, d);
    logic [63:0] big = (ka >= kb) ? x : y;
    logic [63:0] pick;
    if (is_nan(x, d) && is_nan(y, d))      pick = x;
    else if (is_nan(x, d))                 pick = y;
    else if (is_nan(y, d))                 pick = x;
    else case (o)
      2'b00: pick = (ka >= kb) ? y : x;
      2'b01: pick = (ka <= kb) ? y : x;
      2'b10: pick = (ma < mb) ? x : ((ma > mb) ? y : big);
      default: pick = (ma > mb) ? x : ((ma < mb) ? y : big);
    endcase
    return narrow(pick, d);
  endfunction

  function automatic string req_of(logic [63:0] x, logic [63:0] y,
                                   logic [1:0] o, logic d);
    if (is_nan(x, d) && is_nan(y, d)) return "R2";
    if (is_nan(x, d) || is_nan(y, d)) return "R3";
    if (o[1] && magnitude(x, d) == magnitude(y, d)) return "R8";
    case (o)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {63'h0, out_valid}, 64'h0);
    check("R1 in_ready in reset", {63'h0, in_ready}, 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {63'h0, out_valid}, 64'h0);

    // Sweep: all operand pairs, all operations, both precisions.
    for (int d = 1; d >= 0; d--) begin
      for (int o = 0; o < 4; o++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            logic [63:0] x = special(i, d[0]);
            logic [63:0] y = special(j, d[0]);
            if (d == 0) begin   // R9: junk in upper halves
              x[63:32] = 32'hA5A5_0000 | i;
              y[63:32] = 32'h5A5A_F000 | j;
            end
            dbl = d[0]; op = o[1:0]; a = x; b = y; in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check("R10 valid after accept", {63'h0, out_valid}, 64'h1);
            check(d == 0 ? {req_of(x, y, o[1:0], 1'b0), "/R9"} : req_of(x, y, o[1:0], 1'b1),
                  out_data, expect_sel(x, y, o[1:0], d[0]));
            @(negedge clk);
          end
        end
      end
    end
    check("R10 valid falls when idle", {63'h0, out_valid}, 64'h0);

    // Back-pressure, then drain and capture on the same edge.
    out_ready = 1'b0;
    dbl = 1'b1; op = 2'b00;
    a = 64'h3FF0_0000_0000_0000; b = 64'h4000_0000_0000_0000; in_valid = 1'b1;
    @(negedge clk);
    a = 64'hC000_0000_0000_0000; b = 64'h3FF0_0000_0000_0000; op = 2'b01;
    check("R11 in_ready low when stalled", {63'h0, in_ready}, 64'h0);
    check("R4 first result", out_data, 64'h3FF0_0000_0000_0000);
    @(negedge clk);
    check("R11 data held", out_data, 64'h3FF0_0000_0000_0000);
    check("R11 valid held", {63'h0, out_valid}, 64'h1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 drain+load valid", {63'h0, out_valid}, 64'h1);
    check("R5 drain+load data", out_data, 64'h3FF0_0000_0000_0000 ^ 64'h0);
    @(negedge clk);
    check("R10 empty after drain", {63'h0, out_valid}, 64'h0);

    finish_run();
  end
endmodule